// File: doc/BRIEF.md
# Parallel FPGA Configuration Port Master

This block drives the byte-wide slave configuration port of an FPGA from inside a larger chip. It owns every control line of that port (device clear, chip select, write enable, configuration clock) and the tristate control of the 8-bit data bus. Two operations are offered. A load clears the device, waits for it to become ready, and streams an image one byte per rising configuration clock edge. Select and write stay asserted for the whole image. A readback selects the device with write low and returns a given number of bytes on an output stream.

The configuration clock runs at a fraction of the system clock. Each of its levels lasts `DIV` system cycles. Every wait on the device (initialisation, per-byte stall, final ready) is bounded by a timeout of `TIMEOUT_CYC` system cycles. When a wait expires, the block pulses an abort output and reports failure. Each operation ends with a one-cycle completion pulse that carries a pass or fail bit. A command that arrives while an operation is active has no effect.

Top module: `cfgp_master`

## Requirements
- R1: On `load_go` in idle, `dev_clear_o` goes high for one configuration-clock half period and then low, with `dev_sel_o` and `dev_wen_o` low meanwhile.
- R2: After the clear pulse, no select or write is issued while `dev_initing_i` and `dev_stall_i` are both 1. If both stay 1 for `TIMEOUT_CYC` cycles, the load ends with `op_done`=1, `op_ok`=0 and a one-cycle `cfg_abort_o`, and `dev_sel_o` never rises.
- R3: In a load, `dev_wen_o` rises at least one half period before `dev_sel_o`, and `dev_clk_o` rises only after both are high.
- R4: Each load byte is driven on `dev_data_o` with `dev_data_oe`=1 before a rising `dev_clk_o`, with select and write high and the data stable across that edge. Bytes reach the device in stream order, exactly once each.
- R5: With `CHECK_BUSY`=1, while `dev_stall_i` is 1 after a byte's rising edge, the block keeps pulsing `dev_clk_o` without taking a new byte. A stall lasting `TIMEOUT_CYC` cycles ends the load with abort and `op_ok`=0.
- R6: After the last byte, `dev_sel_o` falls, then `dev_wen_o` falls. The clock keeps pulsing until `dev_ready_i` is 1, and the load then ends with `op_ok`=1. If `dev_ready_i` stays 0 for `TIMEOUT_CYC` cycles, the load ends with abort and `op_ok`=0.
- R7: A readback asserts `dev_sel_o` with `dev_wen_o` low. For each of `dump_len` bytes it pulses the clock low then high and presents the bus value sampled one half period after the rising edge on `rd_data` with a one-cycle `rd_valid`. `dump_len`=0 yields no bytes.
- R8: After the last readback byte, `dev_sel_o` falls and exactly one more rising clock edge follows before `op_done`, with `op_ok`=1.
- R9: `dev_data_oe` is 1 only during load data transfer (select and write both high), never in readback or idle.
- R10: `op_done` is a single-cycle pulse. `cfg_abort_o` is 1 only in a cycle where `op_done`=1 and `op_ok`=0.
- R11: `load_go` or `dump_go` while `op_active`=1 is ignored. If both arrive together in idle, the load runs and no readback byte is produced.
- R12: During and after reset, all device control outputs, `dev_data_oe`, `op_active`, `op_done`, `rd_valid` and `cfg_abort_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_go | input | 1 | Start a load (accepted in idle) |
| dump_go | input | 1 | Start a readback (accepted in idle) |
| dump_len | input | LEN_W | Number of bytes to read back |
| ld_data | input | 8 | Load stream byte |
| ld_valid | input | 1 | Load stream byte present |
| ld_last | input | 1 | Load stream byte is the final one |
| ld_ready | output | 1 | Load stream byte taken this cycle |
| rd_data | output | 8 | Readback byte |
| rd_valid | output | 1 | Readback byte present (one cycle) |
| op_active | output | 1 | An operation is in progress |
| op_done | output | 1 | Operation finished (one cycle) |
| op_ok | output | 1 | With op_done: 1 pass, 0 fail |
| cfg_abort_o | output | 1 | Abort pulse on a failed wait |
| dev_clear_o | output | 1 | Device clear (program) request, active high |
| dev_initing_i | input | 1 | Device initialising, active high |
| dev_stall_i | input | 1 | Device busy, active high |
| dev_ready_i | input | 1 | Device configured, active high |
| dev_sel_o | output | 1 | Chip select, active high |
| dev_wen_o | output | 1 | Write enable, active high |
| dev_clk_o | output | 1 | Configuration clock |
| dev_data_o | output | 8 | Data bus output value |
| dev_data_oe | output | 1 | Data bus output enable |
| dev_data_i | input | 8 | Data bus input value |

## Verification
The bench targets each bounded wait separately: a device stuck in initialisation, a device stalled forever after its first byte, and a device that never reports ready. A design that mixed up the timer runs or the exit conditions would hang, succeed falsely, or skip the abort pulse. A finite stall checks that the extra clock pulses are counted exactly and that the stalled byte is not sent twice or skipped. Readback checks the sampling point against a bus value that changes on every rising edge, so a design that captured one edge early or late returns shifted bytes. Zero-length readback and the single trailing pulse catch off-by-one counters. Simultaneous and overlapping commands show whether a busy master restarts or starts the wrong operation.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_PROG,
    ST_INITW,
    ST_WRON,
    ST_CSON,
    ST_CKON,
    ST_FETCH,
    ST_LLOW,
    ST_LHIGH,
    ST_BLOW,
    ST_BHIGH,
    ST_CSOFF,
    ST_WROFF,
    ST_DLOW,
    ST_DHIGH,
    ST_RCS,
    ST_RLOW,
    ST_RHIGH,
    ST_RCSOFF,
    ST_XLOW,
    ST_XHIGH,
    ST_OK,
    ST_FAIL
  } seq_st_e;

  typedef struct packed {
    logic prog;
    logic wen;
    logic sel;
    logic cclk;
    logic oe;
  } pin_s;

  // Pin levels held while the sequencer sits in a state.
  function automatic pin_s pins_of(seq_st_e s);
    pin_s p;
    p = '0;
    unique case (s)
      ST_PROG:   p.prog = 1'b1;
      ST_WRON:   p.wen  = 1'b1;
      ST_CSON:   begin p.wen = 1'b1; p.sel = 1'b1; end
      ST_CKON:   begin p.wen = 1'b1; p.sel = 1'b1; p.cclk = 1'b1; end
      ST_FETCH,
      ST_LHIGH,
      ST_BHIGH:  begin p.wen = 1'b1; p.sel = 1'b1; p.cclk = 1'b1; p.oe = 1'b1; end
      ST_LLOW,
      ST_BLOW:   begin p.wen = 1'b1; p.sel = 1'b1; p.oe = 1'b1; end
      ST_CSOFF:  begin p.wen = 1'b1; p.cclk = 1'b1; end
      ST_WROFF,
      ST_DHIGH,
      ST_RCSOFF,
      ST_XHIGH:  p.cclk = 1'b1;
      ST_RCS,
      ST_RHIGH:  begin p.sel = 1'b1; p.cclk = 1'b1; end
      ST_RLOW:   p.sel = 1'b1;
      default:   p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cfgp_tick.sv
module cfgp_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = !clr && (cnt_q == LAST);

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cfgp_timeout.sv
module cfgp_timeout #(
  parameter int unsigned LIMIT = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run && (cnt_q == LAST);
  assign cnt_en = run ? !expire : (cnt_q != '0);

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq
  import cfgp_pkg::*;
#(
  parameter int unsigned LEN_W      = 8,
  parameter bit          CHECK_BUSY = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tmo,
  input  logic              load_go,
  input  logic              dump_go,
  input  logic [LEN_W-1:0]  dump_len,
  input  logic              ld_valid,
  input  logic              ld_last,
  input  logic [BYTE_W-1:0] ld_data,
  output logic              ld_ready,
  input  logic              dev_initing_i,
  input  logic              dev_stall_i,
  input  logic              dev_ready_i,
  input  logic [BYTE_W-1:0] dev_data_i,
  output pin_s              pins,
  output logic [BYTE_W-1:0] byte_o,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              tmr_run,
  output logic              div_clr,
  output logic              op_active,
  output logic              op_done,
  output logic              op_ok,
  output logic              abort
);

  seq_st_e             st_q, st_d;
  pin_s                pins_q;
  logic [BYTE_W-1:0]   byte_q;
  logic                last_q;
  logic [LEN_W-1:0]    len_q;
  logic [LEN_W-1:0]    cnt_q, cnt_d;
  logic                cnt_en, len_en;
  logic                take, cap;
  logic [BYTE_W-1:0]   rd_q;
  logic                rdv_q, done_q, ok_q, abort_q;
  logic                cnt_hit;
  seq_st_e             after_byte;

  assign after_byte = last_q ? ST_CSOFF : ST_FETCH;
  assign cnt_hit    = ({1'b0, cnt_q} + 1'b1) == {1'b0, len_q};

  // Next-state logic
  always_comb begin
    st_d = st_q;
    take = 1'b0;
    cap  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (load_go)      st_d = ST_PROG;
        else if (dump_go) st_d = ST_RCS;
      end
      ST_PROG:   if (tick) st_d = ST_INITW;
      ST_INITW: begin
        if (tmo) st_d = ST_FAIL;
        else if (tick && !(dev_initing_i && dev_stall_i)) st_d = ST_WRON;
      end
      ST_WRON:   if (tick) st_d = ST_CSON;
      ST_CSON:   if (tick) st_d = ST_CKON;
      ST_CKON:   if (tick) st_d = ST_FETCH;
      ST_FETCH: begin
        if (tick && ld_valid) begin
          take = 1'b1;
          st_d = ST_LLOW;
        end
      end
      ST_LLOW:   if (tick) st_d = ST_LHIGH;
      ST_LHIGH: begin
        if (tick) st_d = (CHECK_BUSY && dev_stall_i) ? ST_BLOW : after_byte;
      end
      ST_BLOW: begin
        if (tmo)       st_d = ST_FAIL;
        else if (tick) st_d = ST_BHIGH;
      end
      ST_BHIGH: begin
        if (tmo)       st_d = ST_FAIL;
        else if (tick) st_d = dev_stall_i ? ST_BLOW : after_byte;
      end
      ST_CSOFF:  if (tick) st_d = ST_WROFF;
      ST_WROFF:  if (tick) st_d = dev_ready_i ? ST_OK : ST_DLOW;
      ST_DLOW: begin
        if (tmo)       st_d = ST_FAIL;
        else if (tick) st_d = ST_DHIGH;
      end
      ST_DHIGH: begin
        if (tmo)       st_d = ST_FAIL;
        else if (tick) st_d = dev_ready_i ? ST_OK : ST_DLOW;
      end
      ST_RCS:    if (tick) st_d = (len_q == '0) ? ST_RCSOFF : ST_RLOW;
      ST_RLOW:   if (tick) st_d = ST_RHIGH;
      ST_RHIGH: begin
        if (tick) begin
          cap  = 1'b1;
          st_d = cnt_hit ? ST_RCSOFF : ST_RLOW;
        end
      end
      ST_RCSOFF: if (tick) st_d = ST_XLOW;
      ST_XLOW:   if (tick) st_d = ST_XHIGH;
      ST_XHIGH:  if (tick) st_d = ST_OK;
      ST_OK:     st_d = ST_IDLE;
      ST_FAIL:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign len_en = (st_q == ST_IDLE) && dump_go && !load_go;
  assign cnt_en = cap || (st_q == ST_RCS);
  assign cnt_d  = (st_q == ST_RCS) ? '0 : cnt_q + 1'b1;

  // State and datapath registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pins_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      abort_q <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      pins_q  <= pins_of(st_d);
      done_q  <= (st_d == ST_OK) || (st_d == ST_FAIL);
      ok_q    <= (st_d == ST_OK);
      abort_q <= (st_d == ST_FAIL);
      rdv_q   <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      last_q <= 1'b0;
    end else if (take) begin
      byte_q <= ld_data;
      last_q <= ld_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= dump_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_q <= '0;
    else if (cap) rd_q <= dev_data_i;
  end

  assign ld_ready  = take;
  assign pins      = pins_q;
  assign byte_o    = byte_q;
  assign rd_data   = rd_q;
  assign rd_valid  = rdv_q;
  assign op_done   = done_q;
  assign op_ok     = ok_q;
  assign abort     = abort_q;
  assign op_active = (st_q != ST_IDLE);
  assign div_clr   = (st_q == ST_IDLE);
  assign tmr_run   = (st_q == ST_INITW) || (st_q == ST_BLOW) || (st_q == ST_BHIGH) ||
                     (st_q == ST_DLOW)  || (st_q == ST_DHIGH);

  // Checks
  AST_CLEAR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_q.prog) |-> !$past(op_active)); // R11
  AST_WEN_BEFORE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pins_q.sel) && pins_q.wen) |-> $past(pins_q.wen)); // R3
  AST_BYTE_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pins_q.cclk) && pins_q.oe) |-> $stable(byte_q)); // R4
  AST_OE_NEEDS_SEL_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    pins_q.oe |-> (pins_q.sel && pins_q.wen)); // R9
  AST_RD_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |-> ($past(pins_q.sel) && !$past(pins_q.wen))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_ABORT_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (done_q && !ok_q)); // R10

endmodule

// File: rtl/cfgp_master.sv
module cfgp_master
  import cfgp_pkg::*;
#(
  parameter int unsigned DIV         = 2,
  parameter int unsigned TIMEOUT_CYC = 500000,
  parameter int unsigned LEN_W       = 8,
  parameter bit          CHECK_BUSY  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_go,
  input  logic             dump_go,
  input  logic [LEN_W-1:0] dump_len,
  input  logic [7:0]       ld_data,
  input  logic             ld_valid,
  input  logic             ld_last,
  output logic             ld_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             op_active,
  output logic             op_done,
  output logic             op_ok,
  output logic             cfg_abort_o,
  output logic             dev_clear_o,
  input  logic             dev_initing_i,
  input  logic             dev_stall_i,
  input  logic             dev_ready_i,
  output logic             dev_sel_o,
  output logic             dev_wen_o,
  output logic             dev_clk_o,
  output logic [7:0]       dev_data_o,
  output logic             dev_data_oe,
  input  logic [7:0]       dev_data_i
);

  logic tick, tmo, tmr_run, div_clr;
  pin_s pins;

  cfgp_tick #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (div_clr),
    .tick  (tick)
  );

  cfgp_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (tmr_run),
    .expire (tmo)
  );

  cfgp_seq #(.LEN_W(LEN_W), .CHECK_BUSY(CHECK_BUSY)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .tmo           (tmo),
    .load_go       (load_go),
    .dump_go       (dump_go),
    .dump_len      (dump_len),
    .ld_valid      (ld_valid),
    .ld_last       (ld_last),
    .ld_data       (ld_data),
    .ld_ready      (ld_ready),
    .dev_initing_i (dev_initing_i),
    .dev_stall_i   (dev_stall_i),
    .dev_ready_i   (dev_ready_i),
    .dev_data_i    (dev_data_i),
    .pins          (pins),
    .byte_o        (dev_data_o),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .tmr_run       (tmr_run),
    .div_clr       (div_clr),
    .op_active     (op_active),
    .op_done       (op_done),
    .op_ok         (op_ok),
    .abort         (cfg_abort_o)
  );

  assign dev_clear_o = pins.prog;
  assign dev_sel_o   = pins.sel;
  assign dev_wen_o   = pins.wen;
  assign dev_clk_o   = pins.cclk;
  assign dev_data_oe = pins.oe;

endmodule

// File: tb/test_cfgp_master.sv
module test_cfgp_master;

  localparam int TMO = 400;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_go, dump_go;
  logic [7:0] dump_len;
  logic [7:0] ld_data;
  logic       ld_valid, ld_last, ld_ready;
  logic [7:0] rd_data;
  logic       rd_valid, op_active, op_done, op_ok, cfg_abort_o;
  logic       dev_clear_o, dev_initing_i, dev_stall_i, dev_ready_i;
  logic       dev_sel_o, dev_wen_o, dev_clk_o, dev_data_oe;
  logic [7:0] dev_data_o, dev_data_i;

  always #10 clk = ~clk;

  cfgp_master #(.DIV(2), .TIMEOUT_CYC(TMO), .LEN_W(8), .CHECK_BUSY(1'b1)) i_cfgp_master (
    .clk(clk), .rst_n(rst_n), .load_go(load_go), .dump_go(dump_go), .dump_len(dump_len),
    .ld_data(ld_data), .ld_valid(ld_valid), .ld_last(ld_last), .ld_ready(ld_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .op_active(op_active), .op_done(op_done),
    .op_ok(op_ok), .cfg_abort_o(cfg_abort_o), .dev_clear_o(dev_clear_o),
    .dev_initing_i(dev_initing_i), .dev_stall_i(dev_stall_i), .dev_ready_i(dev_ready_i),
    .dev_sel_o(dev_sel_o), .dev_wen_o(dev_wen_o), .dev_clk_o(dev_clk_o),
    .dev_data_o(dev_data_o), .dev_data_oe(dev_data_oe), .dev_data_i(dev_data_i)
  );

  // Settings written only by tasks
  int         n_chk = 0, n_bad = 0;
  logic       model_clr;
  int         src_n, init_hold, stall_at, stall_k, done_after;
  logic       busy_force;
  logic [7:0] rb_base;
  logic [7:0] src_mem [0:15];

  // Device model and observers, written only here
  int         src_idx, cap_n, stall_rises, post_rises, rb_n, hold, stall_left, rd_n, done_cnt;
  logic [7:0] cap_mem [0:15];
  logic [7:0] rd_mem  [0:15];
  logic       cclk_d, cs_d, wr_d, init_r, busy_stall;
  logic       prog_seen, oe_seen, order_ok, cs_seen, abort_seen, last_ok;
  logic [7:0] rb_val;

  assign ld_valid      = (src_idx < src_n);
  assign ld_data       = src_mem[src_idx[3:0]];
  assign ld_last       = (src_idx == src_n - 1);
  assign dev_initing_i = init_r;
  assign dev_stall_i   = init_r | busy_stall | busy_force;
  assign dev_ready_i   = (post_rises >= done_after);
  assign dev_data_i    = rb_val;

  always @(posedge clk) begin
    cclk_d <= dev_clk_o;
    cs_d   <= dev_sel_o;
    wr_d   <= dev_wen_o;
    if (model_clr) begin
      src_idx <= 0; cap_n <= 0; stall_rises <= 0; post_rises <= 0; rb_n <= 0;
      hold <= 0; stall_left <= 0; rd_n <= 0; done_cnt <= 0; init_r <= 1'b0;
      busy_stall <= 1'b0; prog_seen <= 1'b0; oe_seen <= 1'b0; order_ok <= 1'b0;
      cs_seen <= 1'b0; abort_seen <= 1'b0; last_ok <= 1'b0; rb_val <= 8'h00;
    end else begin
      if (ld_ready && ld_valid) src_idx <= src_idx + 1;
      if (dev_clear_o) begin
        prog_seen <= 1'b1; init_r <= 1'b1; hold <= init_hold;
      end else if (hold > 0) begin
        hold <= hold - 1;
        if (hold == 1) init_r <= 1'b0;
      end
      if (dev_data_oe) oe_seen <= 1'b1;
      if (dev_sel_o && !cs_d) begin cs_seen <= 1'b1; order_ok <= wr_d; end
      if (rd_valid) begin rd_mem[rd_n[3:0]] <= rd_data; rd_n <= rd_n + 1; end
      if (op_done) begin done_cnt <= done_cnt + 1; last_ok <= op_ok; end
      if (cfg_abort_o) abort_seen <= 1'b1;
      if (dev_clk_o && !cclk_d) begin
        if (dev_sel_o && dev_wen_o) begin
          if (busy_stall) begin
            stall_rises <= stall_rises + 1;
            stall_left  <= stall_left - 1;
            if (stall_left == 1) busy_stall <= 1'b0;
          end else if (dev_data_oe && !busy_force) begin
            cap_mem[cap_n[3:0]] <= dev_data_o;
            cap_n <= cap_n + 1;
            if (cap_n + 1 == stall_at && stall_k > 0) begin
              busy_stall <= 1'b1; stall_left <= stall_k;
            end
          end
        end else if (dev_sel_o && !dev_wen_o) begin
          rb_val <= rb_base + 8'(rb_n * 3);
          rb_n   <= rb_n + 1;
        end else if (!dev_sel_o) begin
          post_rises <= post_rises + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int n, input logic [7:0] base, input int ih, input int sa,
                       input int sk, input int da, input logic bf);
    src_n = 0; init_hold = ih; stall_at = sa; stall_k = sk; done_after = da; busy_force = bf;
    for (int i = 0; i < 16; i++) src_mem[i] = base + 8'(i * 37);
    @(negedge clk); model_clr = 1'b1;
    @(negedge clk); model_clr = 1'b0; src_n = n;
  endtask

  task automatic wait_finish();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_cnt > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_load();
    load_go = 1'b1; @(negedge clk); load_go = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (3) @(negedge clk);
    chk("R12 clear in reset", dev_clear_o, 0);
    chk("R12 ctrl in reset", {dev_sel_o, dev_wen_o, dev_clk_o, dev_data_oe}, 0);
    rst_n = 1'b1; repeat (3) @(negedge clk);
    chk("R12 status after reset", {op_active, op_done, rd_valid, cfg_abort_o}, 0);
    chk("R12 ctrl after reset", {dev_clear_o, dev_sel_o, dev_wen_o, dev_clk_o, dev_data_oe}, 0);
  endtask

  task automatic t_load_basic();
    setup(6, 8'h3C, 20, 0, 0, 3, 1'b0);
    pulse_load(); wait_finish();
    chk("R1 clear pulse seen", prog_seen, 1);
    chk("R3 write before select", order_ok, 1);
    chk("R4 byte count", cap_n, 6);
    for (int i = 0; i < 6; i++) chk("R4 byte value", cap_mem[i], src_mem[i]);
    chk("R6 pulses until ready", post_rises, 3);
    chk("R6 load ok", last_ok, 1);
    chk("R10 single done", done_cnt, 1);
    chk("R10 no abort", abort_seen, 0);
    chk("R12 idle after load", {op_active, dev_sel_o, dev_wen_o, dev_data_oe}, 0);
  endtask

  task automatic t_load_stall();
    setup(5, 8'h81, 10, 2, 4, 2, 1'b0);
    pulse_load(); wait_finish();
    chk("R5 stall pulses", stall_rises, 4);
    chk("R5 byte count", cap_n, 5);
    for (int i = 0; i < 5; i++) chk("R5 byte value", cap_mem[i], src_mem[i]);
    chk("R5 load ok", last_ok, 1);
  endtask

  task automatic t_init_tmo();
    setup(3, 8'h11, 100000, 0, 0, 1, 1'b0);
    pulse_load(); wait_finish();
    chk("R2 fail", last_ok, 0);
    chk("R2 abort", abort_seen, 1);
    chk("R2 no select", cs_seen, 0);
    chk("R10 single done", done_cnt, 1);
  endtask

  task automatic t_busy_tmo();
    setup(3, 8'h55, 10, 0, 0, 1, 1'b1);
    pulse_load(); wait_finish();
    chk("R5 stuck busy fail", last_ok, 0);
    chk("R5 stuck busy abort", abort_seen, 1);
    chk("R5 no byte taken in stall", cap_n, 0);
    chk("R5 stream not advanced", src_idx, 1);
    busy_force = 1'b0;
  endtask

  task automatic t_done_tmo();
    setup(2, 8'h20, 10, 0, 0, 100000, 1'b0);
    pulse_load(); wait_finish();
    chk("R6 ready timeout fail", last_ok, 0);
    chk("R6 ready timeout abort", abort_seen, 1);
    chk("R6 bytes sent", cap_n, 2);
  endtask

  task automatic t_dump(input int len, input logic [7:0] base);
    setup(0, 8'h00, 0, 0, 0, 0, 1'b0);
    rb_base = base; dump_len = 8'(len);
    dump_go = 1'b1; @(negedge clk); dump_go = 1'b0;
    wait_finish();
    chk("R7 readback count", rd_n, len);
    for (int i = 0; i < len; i++) chk("R7 readback value", rd_mem[i], 8'(base + 8'((i + 1) * 3)));
    chk("R8 one trailing pulse", post_rises, 1);
    chk("R8 readback ok", last_ok, 1);
    chk("R9 bus never driven", oe_seen, 0);
    chk("R1 no clear in readback", prog_seen, 0);
  endtask

  task automatic t_reject();
    setup(3, 8'hA0, 10, 0, 0, 2, 1'b0);
    rb_base = 8'h00; dump_len = 8'd3;
    load_go = 1'b1; dump_go = 1'b1; @(negedge clk); load_go = 1'b0; dump_go = 1'b0;
    repeat (30) @(negedge clk);
    dump_go = 1'b1; load_go = 1'b1; @(negedge clk); dump_go = 1'b0; load_go = 1'b0;
    wait_finish();
    chk("R11 load won", cap_n, 3);
    chk("R11 no readback", rd_n, 0);
    chk("R11 single completion", done_cnt, 1);
    chk("R11 ok", last_ok, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_go = 1'b0; dump_go = 1'b0; dump_len = '0; model_clr = 1'b1;
    src_n = 0; init_hold = 0; stall_at = 0; stall_k = 0; done_after = 0;
    busy_force = 1'b0; rb_base = '0;
    t_reset();
    t_load_basic();
    t_load_stall();
    t_init_tmo();
    t_busy_tmo();
    t_done_tmo();
    t_dump(4, 8'h10);
    t_dump(0, 8'h40);
    t_reject();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule